// File: doc/BRIEF.md
# Packed BCD String Adder

This block adds two decimal numbers held in memory as packed-BCD strings and writes the sum back over the second string. A caller gives it a source base address, a destination base address and a length counted in decimal digits, then pulses `start`. The block walks both strings one byte at a time through a single synchronous memory port. Each byte takes three cycles: a source read, a destination read and a write. When it finishes, it presents carry, overflow and zero flags.

Strings are stored least-significant byte first. Each byte holds two digits, with the lower-order digit in bits 3:0. A digit count that is odd stops half-way through the last byte, and the other half of that byte is left as it was. The base addresses and length are captured when the operation starts, so the caller's copies are never altered.

Top module: `bcd_string_adder`

## Requirements
- R1: After an operation, the destination string holds the decimal sum source + destination over the counted digits, stored least-significant byte first with the lower-order digit in bits 3:0. The source string and every byte outside the destination string are unchanged.
- R2: A digit whose sum exceeds 9 wraps modulo 10 and carries 1 into the next digit, including across byte boundaries. `carry_flag` equals the carry out of the most significant counted digit.
- R3: For an odd digit count, the most significant digit is bits 3:0 of the last byte. Bits 7:4 of that byte keep their old destination value, and the source bits 7:4 have no effect on the sum or on any flag.
- R4: `zero_flag` is 1 exactly when every counted digit of both the source and the destination is zero, regardless of the result.
- R5: `ovf_flag` is ten's-complement overflow of the most significant counted digit, where digits 5 to 9 count as negative. It is 1 when both operand digits have the same sign and the result digit has the other sign.
- R6: A digit count of zero performs no memory write and gives `carry_flag`=0, `ovf_flag`=0 and `zero_flag`=1.
- R7: `done` is a single-cycle pulse. It rises 3·ceil(n/2) clock edges after the edge that samples `start`, where n is the digit count. `busy` is high from that edge until the `done` cycle, inclusive.
- R8: While `busy` is high, `start` and the address and count inputs are ignored. The running operation completes once with its original operands.
- R9: Exactly one write is issued per byte of the destination string, and no write falls outside it.
- R10: After reset, `busy`, `done`, `mem_we` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when idle |
| src_addr | input | ADDR_W | Byte address of the source string's low byte |
| dst_addr | input | ADDR_W | Byte address of the destination string's low byte |
| digit_count | input | CNT_W | Length in BCD digits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; flags valid |
| carry_flag | output | 1 | Decimal carry out of the top digit |
| ovf_flag | output | 1 | Ten's-complement overflow of the top digit |
| zero_flag | output | 1 | Both operand strings were all zero |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |

## Verification
The adder is tried with several kinds of input:
- Sums with no carry, which isolate the digit mapping.
- All-nines plus one, which drives a carry through every digit and byte.
- Odd lengths, where a non-zero upper nibble in the source and destination shows that the half-byte is excluded from the sum and the flags.
- Sign-crossing top digits, which separate overflow from carry.
- All-zero operands, including ones whose excluded nibbles are non-zero.
- A zero length issued right after a carrying operation, to show the flags are cleared.

A 32-digit string checks long carry chains. An in-place run with source equal to destination checks the read-before-write order within each byte. A second `start` raised mid-operation with different operands must leave no trace.

// File: rtl/bcd_str_pkg.sv
package bcd_str_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SRC,
      ST_RD_DST,
      ST_WRITE,
      ST_FIN
   } seq_state_t;

   // digits 5..9 are the negative half in ten's complement
   function automatic logic digit_neg(input logic [3:0] d);
      return d >= 4'd5;
   endfunction

endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add (
   input  logic [3:0] a_i,
   input  logic [3:0] b_i,
   input  logic       c_i,
   output logic [3:0] s_o,
   output logic       c_o
);
   logic [4:0] raw;
   logic [4:0] adj;

   always_comb begin
      raw = {1'b0, a_i} + {1'b0, b_i} + {4'b0, c_i};
      c_o = raw > 5'd9;
      adj = c_o ? raw + 5'd6 : raw;
      s_o = adj[3:0];
   end
endmodule

// File: rtl/bcd_byte_add.sv
module bcd_byte_add #(
   parameter int DIGITS = 2,
   localparam int W = 4 * DIGITS
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         c_i,
   input  logic         top_en_i,
   output logic [W-1:0] sum_o,
   output logic         c_o,
   output logic         ovf_o,
   output logic         nz_o
);
   import bcd_str_pkg::*;

   if (DIGITS < 2) begin : g_bad_digits
      $error("bcd_byte_add needs at least two digits");
   end

   logic [DIGITS:0]  chain;
   logic [W-1:0]     raw_sum;

   assign chain[0] = c_i;

   for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      bcd_digit_add u_dig (
         .a_i (a_i[4*g +: 4]),
         .b_i (b_i[4*g +: 4]),
         .c_i (chain[g]),
         .s_o (raw_sum[4*g +: 4]),
         .c_o (chain[g+1])
      );
   end

   int         ms;
   logic [3:0] ma, mb, mr;

   always_comb begin
      ms    = top_en_i ? DIGITS - 1 : DIGITS - 2;
      sum_o = raw_sum;
      if (!top_en_i) sum_o[W-1 -: 4] = b_i[W-1 -: 4];
      c_o   = top_en_i ? chain[DIGITS] : chain[DIGITS-1];
      ma    = a_i[4*ms +: 4];
      mb    = b_i[4*ms +: 4];
      mr    = raw_sum[4*ms +: 4];
      ovf_o = (digit_neg(ma) == digit_neg(mb)) && (digit_neg(mr) != digit_neg(ma));
      nz_o  = 1'b0;
      for (int k = 0; k < DIGITS; k++) begin
         if (k <= ms && (a_i[4*k +: 4] != 4'd0 || b_i[4*k +: 4] != 4'd0)) nz_o = 1'b1;
      end
   end
endmodule

// File: rtl/bcd_str_seq.sv
module bcd_str_seq #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [CNT_W-1:0]  digit_cnt,
   input  logic [7:0]        mem_rdata,
   input  logic              add_cout,
   input  logic              add_ovf,
   input  logic              add_nz,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [7:0]        src_byte,
   output logic              carry_in,
   output logic              top_en,
   output logic              busy,
   output logic              done,
   output logic              cf,
   output logic              of,
   output logic              zf
);
   import bcd_str_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   seq_state_t        st_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [CNT_W-1:0]  idx_q, nb_q, nb_in;
   logic              odd_q, cry_q, nz_q, cf_q, of_q, zf_q, last;
   logic [7:0]        sb_q;

   assign nb_in = {1'b0, digit_cnt[CNT_W-1:1]} + CNT_W'(digit_cnt[0]);
   assign last  = idx_q == nb_q - ONE;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         src_q <= '0;
         dst_q <= '0;
         idx_q <= '0;
         nb_q  <= '0;
         odd_q <= 1'b0;
         cry_q <= 1'b0;
         nz_q  <= 1'b0;
         sb_q  <= '0;
         cf_q  <= 1'b0;
         of_q  <= 1'b0;
         zf_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               src_q <= src_base;
               dst_q <= dst_base;
               nb_q  <= nb_in;
               odd_q <= digit_cnt[0];
               idx_q <= '0;
               cry_q <= 1'b0;
               nz_q  <= 1'b0;
               if (digit_cnt == '0) begin
                  cf_q <= 1'b0;
                  of_q <= 1'b0;
                  zf_q <= 1'b1;
                  st_q <= ST_FIN;
               end else begin
                  st_q <= ST_RD_SRC;
               end
            end
            ST_RD_SRC: st_q <= ST_RD_DST;
            ST_RD_DST: begin
               sb_q <= mem_rdata;
               st_q <= ST_WRITE;
            end
            ST_WRITE: begin
               cry_q <= add_cout;
               nz_q  <= nz_q | add_nz;
               if (last) begin
                  cf_q <= add_cout;
                  of_q <= add_ovf;
                  zf_q <= !(nz_q | add_nz);
                  st_q <= ST_FIN;
               end else begin
                  idx_q <= idx_q + ONE;
                  st_q  <= ST_RD_SRC;
               end
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr = (st_q == ST_RD_SRC) ? src_q + ADDR_W'(idx_q) : dst_q + ADDR_W'(idx_q);
      mem_we   = st_q == ST_WRITE;
      busy     = st_q != ST_IDLE;
      done     = st_q == ST_FIN;
      top_en   = !(last && odd_q);
   end

   assign src_byte = sb_q;
   assign carry_in = cry_q;
   assign cf       = cf_q;
   assign of       = of_q;
   assign zf       = zf_q;

   // R9: writes land only inside the destination string
   a_r9_write_in_dst: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> ((mem_addr - dst_q) < ADDR_W'(nb_q)));

   // R7: completion lasts exactly one cycle
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8: captured operands hold while the operation runs
   a_r8_operands_held: assert property (@(posedge clk) disable iff (rst)
      (busy && !done) |=> ($stable(src_q) && $stable(dst_q) && $stable(nb_q)));

   // R6: empty length finishes at once without writing
   a_r6_empty_no_write: assert property (@(posedge clk) disable iff (rst)
      (!busy && start && digit_cnt == '0) |=> (done && !mem_we));

   // R4: zero operands cannot carry or overflow
   a_r4_zero_clean: assert property (@(posedge clk) disable iff (rst)
      (done && zf) |-> (!cf && !of));
endmodule

// File: rtl/bcd_string_adder.sv
module bcd_string_adder #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [CNT_W-1:0]  digit_count,
   output logic              busy,
   output logic              done,
   output logic              carry_flag,
   output logic              ovf_flag,
   output logic              zero_flag,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   localparam int DIGITS = 2;

   if (CNT_W < 2 || CNT_W > ADDR_W) begin : g_bad_cnt
      $error("CNT_W must be at least 2 and no wider than ADDR_W");
   end

   logic [7:0] src_byte;
   logic       carry_in, top_en, add_cout, add_ovf, add_nz;

   bcd_str_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .src_base  (src_addr),
      .dst_base  (dst_addr),
      .digit_cnt (digit_count),
      .mem_rdata (mem_rdata),
      .add_cout  (add_cout),
      .add_ovf   (add_ovf),
      .add_nz    (add_nz),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .src_byte  (src_byte),
      .carry_in  (carry_in),
      .top_en    (top_en),
      .busy      (busy),
      .done      (done),
      .cf        (carry_flag),
      .of        (ovf_flag),
      .zf        (zero_flag)
   );

   bcd_byte_add #(.DIGITS(DIGITS)) u_add (
      .a_i      (src_byte),
      .b_i      (mem_rdata),
      .c_i      (carry_in),
      .top_en_i (top_en),
      .sum_o    (mem_wdata),
      .c_o      (add_cout),
      .ovf_o    (add_ovf),
      .nz_o     (add_nz)
   );

   // R10: quiet outputs in the cycle after reset
   a_r10_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (!busy && !done && !mem_we));
endmodule

// File: tb/bcd_string_adder_test.sv
`timescale 1ns/1ps
module bcd_string_adder_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] src_addr = '0, dst_addr = '0;
   logic [7:0]  digit_count = '0;
   logic        busy, done, carry_flag, ovf_flag, zero_flag, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   always #2 clk = ~clk;

   bcd_string_adder uut (
      .clk(clk), .rst(rst), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
      .digit_count(digit_count), .busy(busy), .done(done), .carry_flag(carry_flag),
      .ovf_flag(ovf_flag), .zero_flag(zero_flag), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // memory model, bench poke port, write accounting
   logic [7:0]  mem [256];
   logic [7:0]  exp_mem [256];
   logic        ld_en = 1'b0;
   logic [7:0]  ld_addr = '0, ld_data = '0;
   int unsigned cyc = 0, wr_cnt = 0, bad_wr = 0, cur_nb = 0;
   logic [15:0] cur_dst = '0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (ld_en) mem[ld_addr] <= ld_data;
      if (mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
         if (32'(mem_addr - cur_dst) >= cur_nb) bad_wr <= bad_wr + 1;
      end
      mem_rdata <= mem[mem_addr[7:0]];
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic        cf;
      logic        ovf;
      logic        zf;
      int unsigned due;
      int unsigned w0;
      int unsigned wexp;
      int unsigned bad0;
   } exp_t;
   exp_t sb_q[$];

   // monitor: pops one expected item per completion
   always @(negedge clk) begin
      if (!rst && done) begin
         if (sb_q.size() == 0) chk("R8 unexpected done", 1, 0);
         else begin
            exp_t e;
            int mism, fa;
            e = sb_q.pop_front();
            chk("R2 carry_flag", int'(carry_flag), int'(e.cf));
            chk("R5 ovf_flag", int'(ovf_flag), int'(e.ovf));
            chk("R4 zero_flag", int'(zero_flag), int'(e.zf));
            chk("R7 done cycle", int'(cyc), int'(e.due));
            chk("R9 R6 write count", int'(wr_cnt - e.w0), int'(e.wexp));
            chk("R9 writes outside dst", int'(bad_wr - e.bad0), 0);
            mism = 0; fa = -1;
            for (int i = 0; i < 256; i++)
               if (mem[i] !== exp_mem[i]) begin mism++; if (fa < 0) fa = i; end
            if (fa >= 0) $display("  byte %0d actual=%h expected=%h", fa, mem[fa], exp_mem[fa]);
            chk("R1 R3 memory mismatches", mism, 0);
         end
      end
   end

   task automatic poke(input int a, input logic [7:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(a); ld_data = d;
      exp_mem[a] = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic load(input int base, input int nb, input logic [127:0] v);
      for (int i = 0; i < nb; i++) poke(base + i, v[8*i +: 8]);
   endtask

   function automatic int dig(input int base, input int k);
      return int'((exp_mem[base + k/2] >> (4 * (k % 2))) & 8'h0F);
   endfunction

   task automatic setdig(input int base, input int k, input int v);
      int a;
      a = base + k/2;
      if (k % 2 == 1) exp_mem[a] = {4'(v), exp_mem[a][3:0]};
      else exp_mem[a] = {exp_mem[a][7:4], 4'(v)};
   endtask

   // driver: builds the expected result, starts the op, waits for it
   task automatic run_op(input int s, input int d, input int cnt, input bit disturb);
      int c, nz, ov, a, b, t, r, nb;
      exp_t e;
      c = 0; nz = 0; ov = 0;
      for (int k = 0; k < cnt; k++) begin
         a = dig(s, k); b = dig(d, k);
         t = a + b + c;
         c = (t > 9) ? 1 : 0;
         r = c ? t - 10 : t;
         if (k == cnt - 1) ov = (((a >= 5) == (b >= 5)) && ((r >= 5) != (a >= 5))) ? 1 : 0;
         if (a != 0 || b != 0) nz = 1;
         setdig(d, k, r);
      end
      nb = (cnt + 1) / 2;
      cur_dst = 16'(d); cur_nb = nb;
      @(negedge clk);
      start = 1'b1; src_addr = 16'(s); dst_addr = 16'(d); digit_count = 8'(cnt);
      @(posedge clk); #1;
      e.cf = c[0]; e.ovf = ov[0]; e.zf = (nz == 0);
      e.due = cyc + 3 * nb; e.w0 = wr_cnt; e.wexp = nb; e.bad0 = bad_wr;
      sb_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      if (nb > 0) chk("R7 busy while running", int'(busy), 1);
      if (disturb) begin
         // R8: second request while busy must be ignored
         start = 1'b1; src_addr = 16'h0080; dst_addr = 16'h0090; digit_count = 8'd5;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   localparam int SRC = 16;
   localparam int DST = 64;

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10: reset state
      chk("R10 busy", int'(busy), 0);
      chk("R10 done", int'(done), 0);
      chk("R10 mem_we", int'(mem_we), 0);
      chk("R10 flags", int'({carry_flag, ovf_flag, zero_flag}), 0);

      for (int i = 0; i < 256; i++) poke(i, 8'(i * 37 + 11));

      // R1: plain sum 1234 + 5678
      load(SRC, 2, 128'h1234); load(DST, 2, 128'h5678);
      run_op(SRC, DST, 4, 0);
      // R2: carry ripples through every digit, 9999 + 0001
      load(SRC, 2, 128'h9999); load(DST, 2, 128'h0001);
      run_op(SRC, DST, 4, 0);
      // R6: empty length right after a carry clears CF
      run_op(SRC, DST, 0, 0);
      // R3: odd length, 999 + 001 with non-zero upper nibbles
      load(SRC, 2, 128'h8999); load(DST, 2, 128'h5001);
      run_op(SRC, DST, 3, 0);
      // R3 R4: counted digits zero, excluded nibbles not
      load(SRC, 2, 128'h9000); load(DST, 2, 128'h6000);
      run_op(SRC, DST, 3, 0);
      // R4: all-zero operands over six digits
      load(SRC, 3, 128'h0); load(DST, 3, 128'h0);
      run_op(SRC, DST, 6, 0);
      // R5: 45 + 44 crosses sign without carry
      load(SRC, 1, 128'h45); load(DST, 1, 128'h44);
      run_op(SRC, DST, 2, 0);
      // R5: 60 + 70 overflows with carry
      load(SRC, 1, 128'h60); load(DST, 1, 128'h70);
      run_op(SRC, DST, 2, 0);
      // R3: single digit 7 + 5
      load(SRC, 1, 128'h37); load(DST, 1, 128'h95);
      run_op(SRC, DST, 1, 0);
      // R1 R2: 32-digit operands
      load(SRC, 16, 128'h12345678901234567890123456789012);
      load(DST, 16, 128'h98765432109876543210987654321098);
      run_op(SRC, DST, 32, 0);
      // R1: in place, source equals destination, 2550 doubled
      load(DST, 2, 128'h2550);
      run_op(DST, DST, 4, 0);
      // R8: start pulsed mid-operation with other operands
      load(SRC, 3, 128'h123456); load(DST, 3, 128'h654321);
      run_op(SRC, DST, 6, 1);

      repeat (20) @(negedge clk);
      chk("R8 no pending completions", sb_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule